// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Mode Control

This block is a full-duplex asynchronous serial port. A transmitter serializes bytes handed to it through a valid/ready handshake, and a receiver samples the incoming line and reports each byte with framing and parity status. Both sides use a frame shape chosen by a small mode register: one or two stop bits, an optional parity bit (even or odd), or a multiprocessor format in which a single address/data flag bit takes the parity bit's place.

Bit timing comes from a chain of two counters. A prescaler divides the system clock by 1, 4, 16 or 64. Its output advances a programmable bit-rate counter, which emits a 16x oversampling tick. Every bit on the line lasts 16 ticks. The receiver qualifies a start bit at its middle and then samples each later bit at its middle. It checks only the first stop bit, so a second stop position that is low begins the next character.

Top module: `uart_mode_xcvr`

## Requirements
- R1: Writes with `reg_sel`=0 load the mode register from `reg_wdata[5:0]`, with bit 5 = two stop bits, bit 4 = multiprocessor format, bit 3 = parity enable, bit 2 = odd parity and bits 1:0 = clock select. Writes with `reg_sel`=1 load the rate value. Both registers reset to zero, which gives one stop bit, no parity, no multiprocessor bit and divide-by-1. After reset `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: An accepted byte is sent in this order: a start bit of 0, then the 8 data bits LSB first, then the stop bits of 1. `tx_ready` falls in the cycle after acceptance and `txd` goes low in that same cycle.
- R3: With two stop bits selected, the transmitter stays busy through a second stop bit of 1. With one stop bit it is ready again after the first stop bit.
- R4: With parity enabled and multiprocessor format off, one parity bit follows the data bits. In even mode the data and parity bits together hold an even number of ones; in odd mode they hold an odd number.
- R5: With multiprocessor format on, exactly one extra bit follows the data: `tx_mpb` on transmit, reported on `rx_mpb` on receive. Parity enable and odd select are ignored, and `rx_perr` stays 0.
- R6: The tick period is (rate+1) × D system clocks, where D is 1, 4, 16 or 64 for clock select 00, 01, 10 or 11. Every bit lasts 16 ticks, and `txd` changes only in the cycle after a tick.
- R7: A received frame is reported by a one-cycle `rx_valid` pulse carrying the byte on `rx_data`.
- R8: A low level on the line that reads 1 at the middle of the start bit is discarded and produces no `rx_valid`.
- R9: A first stop bit sampled as 0 sets `rx_ferr` with the byte.
- R10: With parity checking active, a received parity bit that does not match the data sets `rx_perr`; a matching bit leaves it 0.
- R11: Only the first stop bit is checked. A 0 in the second stop position is taken as the start bit of the next character, and that character is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the rate value |
| reg_wdata | input | 8 | Register write data |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_mpb | input | 1 | Multiprocessor flag sent with the byte |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| rx_valid | output | 1 | One-cycle pulse when a received byte is reported |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received multiprocessor flag |
| rx_ferr | output | 1 | Framing error for the reported byte |
| rx_perr | output | 1 | Parity error for the reported byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The hardest case to reach from the ports is a character whose second stop position is low. The receiver has to give up the first frame at mid-stop and then catch a start edge that arrives only half a bit later. A transmitter never produces this frame, so the bench drives `rxd` directly from an arithmetically built bit vector in which the second stop bit is left out. It also drives start pulses shorter than half a bit and stop bits held low, to check that the mid-bit start qualification does not turn the line level after a framing error into a false character. Every mode combination and every clock select is also checked in loopback, with `txd` fed back into `rxd`.

// File: rtl/uxc_pkg.sv
package uxc_pkg;

    localparam int PRE_W = 6;

    typedef struct packed {
        logic       two_stop;
        logic       mp_en;
        logic       par_en;
        logic       par_odd;
        logic [1:0] clk_sel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } rx_st_e;

endpackage

// File: rtl/uxc_baud.sv
module uxc_baud
    import uxc_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [1:0]        clk_sel,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    typedef struct packed {
        logic [PRE_W-1:0]  pre_cnt;
        logic [RATE_W-1:0] rate_cnt;
    } baud_t;

    baud_t st_d, st_q;
    logic [PRE_W-1:0] pre_last;
    logic             pre_hit;

    always_comb begin
        pre_last = PRE_W'((7'd1 << {clk_sel, 1'b0}) - 7'd1);
        pre_hit  = (st_q.pre_cnt == pre_last);
        tick     = pre_hit && (st_q.rate_cnt == rate);
        st_d     = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.pre_cnt = pre_hit ? '0 : st_q.pre_cnt + 1'b1;
            if (pre_hit) begin
                st_d.rate_cnt = (st_q.rate_cnt == rate) ? '0 : st_q.rate_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && (clk_sel != 2'b00 || rate != '0)) |=> !tick) // R6
        else $error("tick period too short");

endmodule

// File: rtl/uxc_tx.sv
module uxc_tx
    import uxc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  mode_t             mode,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mpb,
    output logic              tx_ready,
    output logic              txd
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int PH_W    = $clog2(OVS);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [IDX_W-1:0]   left;
        logic [PH_W-1:0]    ph;
    } tx_t;

    tx_t st_d, st_q;
    logic               has_extra;
    logic               extra_bit;
    logic [FRAME_W-1:0] frame;

    always_comb begin
        has_extra = mode.mp_en | mode.par_en;
        extra_bit = mode.mp_en ? tx_mpb : ((^tx_data) ^ mode.par_odd);
        frame            = '1;
        frame[0]         = 1'b0;
        frame[DATA_W:1]  = tx_data;
        frame[DATA_W+1]  = has_extra ? extra_bit : 1'b1;

        st_d = st_q;
        if (!st_q.busy) begin
            if (tx_valid) begin
                st_d.busy = 1'b1;
                st_d.sh   = frame;
                st_d.ph   = '0;
                st_d.left = IDX_W'(DATA_W + 2) + IDX_W'(has_extra) + IDX_W'(mode.two_stop);
            end
        end else if (tick) begin
            if (st_q.ph == PH_W'(OVS - 1)) begin
                st_d.ph   = '0;
                st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == IDX_W'(1)) st_d.busy = 1'b0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, sh: '1, left: '0, ph: '0};
        else        st_q <= st_d;
    end

    assign tx_ready = !st_q.busy;
    assign txd      = st_q.busy ? st_q.sh[0] : 1'b1;

    AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready) // R2
        else $error("accept did not start a frame");

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !txd) // R2
        else $error("frame did not begin with a start bit");

    AST_TX_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready) && !$past(tick)) |-> $stable(txd)) // R6
        else $error("line moved without a tick");

endmodule

// File: rtl/uxc_rx.sv
module uxc_rx
    import uxc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  mode_t             mode,
    input  logic              rxd,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_mpb,
    output logic              rx_ferr,
    output logic              rx_perr
);

    localparam int PH_W  = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    typedef struct packed {
        logic [SYNC_W-1:0] sync;
        rx_st_e            st;
        logic [PH_W-1:0]   ph;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              ext;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              ferr;
        logic              perr;
    } rx_t;

    rx_t  st_d, st_q;
    logic rxs;
    logic has_extra;

    always_comb begin
        rxs       = st_q.sync[SYNC_W-1];
        has_extra = mode.mp_en | mode.par_en;
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = {st_q.sync[SYNC_W-2:0], rxd};
        case (st_q.st)
            RX_IDLE: begin
                if (tick && !rxs) begin
                    st_d.st = RX_START;
                    st_d.ph = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (st_q.ph == PH_MID) begin
                        st_d.ph  = '0;
                        st_d.idx = '0;
                        st_d.st  = rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        st_d.ph = st_q.ph + 1'b1;
                    end
                end
            end
            RX_BITS: begin
                if (tick) begin
                    if (st_q.ph == PH_LAST) begin
                        st_d.ph  = '0;
                        st_d.idx = st_q.idx + 1'b1;
                        if (st_q.idx < IDX_W'(DATA_W)) begin
                            st_d.sh = {rxs, st_q.sh[DATA_W-1:1]};
                        end else if (st_q.idx == IDX_W'(DATA_W) && has_extra) begin
                            st_d.ext = rxs;
                        end else begin
                            st_d.st    = RX_IDLE;
                            st_d.valid = 1'b1;
                            st_d.data  = st_q.sh;
                            st_d.ferr  = !rxs;
                            st_d.mpb   = mode.mp_en & st_q.ext;
                            st_d.perr  = mode.par_en && !mode.mp_en &&
                                         (st_q.ext != ((^st_q.sh) ^ mode.par_odd));
                        end
                    end else begin
                        st_d.ph = st_q.ph + 1'b1;
                    end
                end
            end
            default: st_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sync <= '1;
            st_q.st   <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid = st_q.valid;
    assign rx_data  = st_q.data;
    assign rx_mpb   = st_q.mpb;
    assign rx_ferr  = st_q.ferr;
    assign rx_perr  = st_q.perr;

    AST_RX_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid) // R7
        else $error("rx_valid held longer than one cycle");

    AST_RX_MP_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(mode.mp_en)) |-> !rx_perr) // R5
        else $error("parity error flagged in multiprocessor format");

endmodule

// File: rtl/uart_mode_xcvr.sv
module uart_mode_xcvr
    import uxc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RATE_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [RATE_W-1:0] reg_wdata,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_mpb,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_mpb,
    output logic              rx_ferr,
    output logic              rx_perr,
    output logic              txd,
    input  logic              rxd
);

    typedef struct packed {
        mode_t             mode;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic tick;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            if (reg_sel) cfg_d.rate = reg_wdata;
            else         cfg_d.mode = mode_t'(reg_wdata[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    uxc_baud #(.RATE_W(RATE_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (reg_we),
        .clk_sel (cfg_q.mode.clk_sel),
        .rate    (cfg_q.rate),
        .tick    (tick)
    );

    uxc_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (cfg_q.mode),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_mpb   (tx_mpb),
        .tx_ready (tx_ready),
        .txd      (txd)
    );

    uxc_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_W(2)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (cfg_q.mode),
        .rxd      (rxd),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_mpb   (rx_mpb),
        .rx_ferr  (rx_ferr),
        .rx_perr  (rx_perr)
    );

endmodule

// File: tb/uart_mode_xcvr_tb.sv
module uart_mode_xcvr_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_mpb = 1'b0;
    logic       tx_ready, rx_valid, rx_mpb, rx_ferr, rx_perr, txd;
    logic [7:0] rx_data;
    logic       loop_en = 1'b1;
    logic       drv_rx = 1'b1;
    logic       rxd;

    int n_chk = 0;
    int n_bad = 0;
    int n_rx  = 0;
    logic [7:0] cap_data;
    logic       cap_mpb, cap_ferr, cap_perr;
    bit         done = 1'b0;

    assign rxd = loop_en ? txd : drv_rx;

    always #(CLK_P / 2) clk = ~clk;

    uart_mode_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_mpb(tx_mpb), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_ferr(rx_ferr),
        .rx_perr(rx_perr), .txd(txd), .rxd(rxd)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            n_rx++;
            cap_data = rx_data;
            cap_mpb  = rx_mpb;
            cap_ferr = rx_ferr;
            cap_perr = rx_perr;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic wr(input logic sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_mode(input logic ts, input logic mp, input logic pe,
                            input logic odd, input logic [1:0] cs, input logic [7:0] rate);
        wr(1'b0, {2'b00, ts, mp, pe, odd, cs});
        wr(1'b1, rate);
    endtask

    function automatic int flen(input logic ts, input logic mp, input logic pe);
        return 10 + int'(mp | pe) + int'(ts);
    endfunction

    function automatic logic [15:0] fbits(input logic [7:0] d, input logic mp,
                                          input logic pe, input logic odd, input logic mpb);
        logic [15:0] v = '1;
        v[0]   = 1'b0;
        v[8:1] = d;
        if (mp)      v[9] = mpb;
        else if (pe) v[9] = (^d) ^ odd;
        return v;
    endfunction

    // Loopback transmit with bit-by-bit line check and receive check.
    task automatic tx_check(input logic [7:0] d, input logic mpb, input logic ts,
                            input logic mp, input logic pe, input logic odd, input int P);
        int          n    = flen(ts, mp, pe);
        logic [15:0] v    = fbits(d, mp, pe, odd, mpb);
        int          base = n_rx;
        string       req;
        @(negedge clk);
        tx_data = d; tx_mpb = mpb; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R2 ready low after accept", int'(tx_ready), 0);
        repeat (P / 2) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            if (k == 9 && (mp | pe)) req = mp ? "R5 mp bit" : "R4 parity bit";
            else if (k == n - 1 && ts) req = "R3 second stop";
            else req = "R2 frame bit";
            chk(req, int'(txd), int'(v[k]));
            if (k == n - 1) chk("R3 busy in last stop", int'(tx_ready), 0);
            repeat (P) @(negedge clk);
        end
        chk("R3 ready after stops", int'(tx_ready), 1);
        chk("R2 idle mark", int'(txd), 1);
        chk("R7 one frame received", n_rx, base + 1);
        chk("R7 rx data", int'(cap_data), int'(d));
        chk("R5 rx mp flag", int'(cap_mpb), int'(mp & mpb));
        chk("R10 no parity error", int'(cap_perr), 0);
        chk("R9 no framing error", int'(cap_ferr), 0);
    endtask

    task automatic drive_bits(input logic [31:0] bits, input int n, input int P);
        for (int i = 0; i < n; i++) begin
            drv_rx = bits[i];
            repeat (P) @(negedge clk);
        end
        drv_rx = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        logic [31:0] w;
        int          base;
        repeat (3) @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset tx_ready", int'(tx_ready), 1);
        chk("R1 reset rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 txd after reset", int'(txd), 1);
        // R1: defaults give one stop, no parity, divide-by-1, rate 0 (P=16).
        tx_check(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16);

        // Full format sweep in loopback at P=16 (R2 R3 R4 R5 R7).
        for (int m = 0; m < 16; m++) begin
            logic ts = m[3], mp = m[2], pe = m[1], odd = m[0];
            logic [7:0] b = 8'((m * 37 + 5) & 255);
            set_mode(ts, mp, pe, odd, 2'b00, 8'd0);
            tx_check(b, b[0], ts, mp, pe, odd, 16);
            tx_check(b ^ 8'hA5, ~b[0], ts, mp, pe, odd, 16);
        end

        // Clock select and rate sweep (R6).
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'd3);
        tx_check(8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16 * 4);
        for (int cs = 1; cs < 4; cs++) begin
            set_mode(1'b0, 1'b0, 1'b0, 1'b0, 2'(cs), 8'd1);
            tx_check(8'h55 ^ 8'(cs), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16 * 2 * (1 << (2 * cs)));
        end

        // Direct receive cases at P=16.
        loop_en = 1'b0;
        drv_rx  = 1'b1;
        set_mode(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 8'd0);
        repeat (40) @(negedge clk);

        // R10: even parity, wrong parity bit.
        base = n_rx;
        w = 32'hFFFF_FFFF; w[0] = 1'b0; w[8:1] = 8'hB3; w[9] = ~(^8'hB3);
        drive_bits(w, 11, 16); repeat (32) @(negedge clk);
        chk("R10 frame count", n_rx, base + 1);
        chk("R10 parity error set", int'(cap_perr), 1);
        chk("R10 data", int'(cap_data), 'hB3);
        // R10: correct parity bit.
        w[9] = ^8'hB3;
        drive_bits(w, 11, 16); repeat (32) @(negedge clk);
        chk("R10 parity ok", int'(cap_perr), 0);

        // R5: multiprocessor format with parity also enabled; parity ignored.
        set_mode(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 8'd0);
        repeat (20) @(negedge clk);
        base = n_rx;
        w = 32'hFFFF_FFFF; w[0] = 1'b0; w[8:1] = 8'h0F; w[9] = 1'b1;
        drive_bits(w, 11, 16); repeat (32) @(negedge clk);
        chk("R5 frame count", n_rx, base + 1);
        chk("R5 mp flag reported", int'(cap_mpb), 1);
        chk("R5 parity ignored", int'(cap_perr), 0);
        chk("R5 data", int'(cap_data), 'h0F);

        // R9: stop bit low, no parity.
        set_mode(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 8'd0);
        repeat (20) @(negedge clk);
        base = n_rx;
        w = 32'hFFFF_FFFF; w[0] = 1'b0; w[8:1] = 8'h81; w[9] = 1'b0;
        drive_bits(w, 10, 16); repeat (64) @(negedge clk);
        chk("R9 frame count", n_rx, base + 1);
        chk("R9 framing error set", int'(cap_ferr), 1);
        chk("R9 data", int'(cap_data), 'h81);

        // R8: short low pulse is discarded.
        base = n_rx;
        drv_rx = 1'b0; repeat (3) @(negedge clk); drv_rx = 1'b1;
        repeat (64) @(negedge clk);
        chk("R8 glitch ignored", n_rx, base);
        w = 32'hFFFF_FFFF; w[0] = 1'b0; w[8:1] = 8'h6E;
        drive_bits(w, 10, 16); repeat (32) @(negedge clk);
        chk("R8 next frame count", n_rx, base + 1);
        chk("R8 next frame data", int'(cap_data), 'h6E);

        // R11: two-stop mode, second stop replaced by the next start bit.
        set_mode(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'd0);
        repeat (20) @(negedge clk);
        base = n_rx;
        w = 32'hFFFF_FFFF;
        w[0] = 1'b0; w[8:1] = 8'hC4; w[9] = 1'b1;
        w[10] = 1'b0; w[18:11] = 8'h2B; w[19] = 1'b1; w[20] = 1'b1;
        drive_bits(w, 10, 16);
        chk("R11 first frame count", n_rx, base + 1);
        chk("R11 first data", int'(cap_data), 'hC4);
        chk("R11 first no ferr", int'(cap_ferr), 0);
        drive_bits(w >> 10, 11, 16); repeat (32) @(negedge clk);
        chk("R11 second frame count", n_rx, base + 2);
        chk("R11 second data", int'(cap_data), 'h2B);
        chk("R11 second no ferr", int'(cap_ferr), 0);

        done = 1'b1;
        summary();
    end

endmodule